// File: doc/BRIEF.md
# Thyristor Indication-Pulse Supervisor

This block sits in the controller of a three-phase thyristor bypass switch. The switch has six thyristor control units, wired as three anti-parallel pairs in a delta. Each unit sends back an active-low indication pulse on its own line. The block conditions those lines and counts the pulses that arrive in each mains period. From the count it decides, for every unit, whether the unit is energised, whether it has reported an overvoltage, or whether it has gone silent.

When a unit reports an overvoltage, the block latches a fault mark for that unit and commands every other unit to fire, so that the whole bridge bypasses together. When a unit stays silent for several whole mains periods, the block marks it dead and raises a disconnect request to the master controller. Recovery is manual, so every mark, fire command and request holds until the clear input is pulsed.

At every mains-period boundary the block also presents a one-clock snapshot of all unit flags for the master controller.

Top module: `tcu_pulse_supervisor`

## Requirements
- R1: While rst_n is low, and after its release until an event occurs, fire_cmd, energised, ov_mark, dead_mark, disconnect_req, status_valid and status_word are all zero.
- R2: A low level on ind_n[i] counts as an indication pulse only once the synchronised line has read low for FILT_CLKS consecutive clocks. A shorter low glitch has no effect. The line must read high for FILT_CLKS clocks before a new pulse can be seen.
- R3: The first recognised pulse from unit i sets energised[i].
- R4: Mains periods are CYCLE_TICKS clocks long, and a boundary falls on every CYCLE_TICKS-th clock after reset. A second recognised pulse from unit i within one period sets ov_mark[i]. One pulse per period, or two pulses in adjacent periods, never sets it. A pulse that is taken on a boundary clock counts toward the new period.
- R5: One clock after ov_mark[j] is set, fire_cmd[i] is high for every i other than j. fire_cmd[j] rises only if another unit also has its ov_mark set.
- R6: Unit i gets dead_mark[i] when DEAD_CYCLES consecutive complete periods pass with no recognised pulse from it. Any pulse restarts that count.
- R7: disconnect_req rises one clock after any dead_mark bit is set.
- R8: Marks, fire commands and the disconnect request hold until clear. A clock with clear high zeroes energised, ov_mark, dead_mark, fire_cmd, disconnect_req and the per-unit pulse and silence counts in that same edge.
- R9: At each period boundary, status_valid is high for exactly one clock. status_word then holds the flags as they were before that edge: bits [N-1:0] energised, bits [2N-1:N] ov_mark, bits [3N-1:2N] dead_mark, with unit i at offset i inside each field. status_word holds its value between boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Manual recovery: clears all marks and commands |
| ind_n | input | N_UNITS | Active-low indication lines, one per unit |
| fire_cmd | output | N_UNITS | Latched protective-fire command per unit |
| energised | output | N_UNITS | Unit has sent its first pulse |
| ov_mark | output | N_UNITS | Latched overvoltage mark per unit |
| dead_mark | output | N_UNITS | Latched silent-unit mark per unit |
| disconnect_req | output | 1 | Latched request to disconnect the equipment |
| status_valid | output | 1 | One-clock strobe at each period boundary |
| status_word | output | 3*N_UNITS | Flag snapshot taken at the last boundary |

## Verification
The cases hardest to reach from the ports are the ones that depend on where a pulse falls against the period boundary. This matters because the filter and synchroniser delay every pulse by several clocks. The bench places one pulse near the end of a period and the next early in the following period, and expects no overvoltage. It keeps one unit silent for one period fewer than the dead limit and then lets it pulse, and holds another silent for the full limit. The bench shortens the mains period through a parameter, and a clock-by-clock behavioural model tracks the boundary position, so every output is compared on every clock.

// File: rtl/tcu_sup_pkg.sv
package tcu_sup_pkg;

    // Number of per-unit flag fields carried in the status word
    localparam int unsigned FIELDS = 3;

    // Pulses seen in the current mains period, saturating
    typedef enum logic [1:0] {
        CNT_NONE = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_MANY = 2'd2
    } pcount_e;

endpackage

// File: rtl/tcu_in_cond.sv
module tcu_in_cond #(
    parameter int unsigned FILT_CLKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic pulse_o
);
    localparam int unsigned CW = $clog2(FILT_CLKS + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
        logic          pulse;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = ~line_n;
        st_d.s2    = st_q.s1;
        st_d.pulse = 1'b0;
        if (st_q.s2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(FILT_CLKS - 1)) begin
            st_d.cnt   = '0;
            st_d.filt  = st_q.s2;
            st_d.pulse = st_q.s2;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

endmodule

// File: rtl/tcu_cycle_timer.sv
module tcu_cycle_timer #(
    parameter int unsigned CYCLE_TICKS = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic cyc_end_o
);
    localparam int unsigned TW = (CYCLE_TICKS > 2) ? $clog2(CYCLE_TICKS) : 1;

    logic [TW-1:0] tick_d, tick_q;

    assign cyc_end_o = (tick_q == TW'(CYCLE_TICKS - 1));

    always_comb begin
        tick_d = cyc_end_o ? '0 : tick_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

endmodule

// File: rtl/tcu_unit_monitor.sv
module tcu_unit_monitor
    import tcu_sup_pkg::*;
#(
    parameter int unsigned DEAD_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic pulse_i,
    input  logic cyc_end_i,
    output logic pow_o,
    output logic ov_o,
    output logic dead_o
);
    localparam int unsigned SW = $clog2(DEAD_CYCLES + 1);

    typedef struct packed {
        logic          pow;
        logic          ov;
        logic          dead;
        pcount_e       cnt;
        logic [SW-1:0] silent;
    } unit_t;

    unit_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (cyc_end_i) begin
                if (st_q.cnt == CNT_NONE) begin
                    if (!st_q.dead) begin
                        st_d.silent = st_q.silent + 1'b1;
                        if (st_q.silent == SW'(DEAD_CYCLES - 1)) st_d.dead = 1'b1;
                    end
                end else begin
                    st_d.silent = '0;
                end
                st_d.cnt = CNT_NONE;
            end
            if (pulse_i) begin
                st_d.pow    = 1'b1;
                st_d.silent = '0;
                if (st_d.cnt != CNT_NONE) begin
                    st_d.ov  = 1'b1;
                    st_d.cnt = CNT_MANY;
                end else begin
                    st_d.cnt = CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pow_o  = st_q.pow;
    assign ov_o   = st_q.ov;
    assign dead_o = st_q.dead;

    // R4
    ov_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ov) |-> $past(pulse_i));

    // R3
    ov_after_energise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov |-> st_q.pow);

    // R6
    dead_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dead) |-> $past(cyc_end_i));

endmodule

// File: rtl/tcu_pulse_supervisor.sv
module tcu_pulse_supervisor
    import tcu_sup_pkg::*;
#(
    parameter int unsigned N_UNITS     = 6,
    parameter int unsigned CYCLE_TICKS = 1_000_000,
    parameter int unsigned FILT_CLKS   = 40,
    parameter int unsigned DEAD_CYCLES = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic [N_UNITS-1:0]           ind_n,
    output logic [N_UNITS-1:0]           fire_cmd,
    output logic [N_UNITS-1:0]           energised,
    output logic [N_UNITS-1:0]           ov_mark,
    output logic [N_UNITS-1:0]           dead_mark,
    output logic                         disconnect_req,
    output logic                         status_valid,
    output logic [FIELDS*N_UNITS-1:0]    status_word
);
    localparam int unsigned STW = FIELDS * N_UNITS;

    logic               cyc_end;
    logic [N_UNITS-1:0] pulse_w, pow_w, ov_w, dead_w;

    tcu_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_end_o(cyc_end)
    );

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        tcu_in_cond #(.FILT_CLKS(FILT_CLKS)) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_n (ind_n[g]),
            .pulse_o(pulse_w[g])
        );
        tcu_unit_monitor #(.DEAD_CYCLES(DEAD_CYCLES)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear),
            .pulse_i  (pulse_w[g]),
            .cyc_end_i(cyc_end),
            .pow_o    (pow_w[g]),
            .ov_o     (ov_w[g]),
            .dead_o   (dead_w[g])
        );
    end

    typedef struct packed {
        logic [N_UNITS-1:0] fire;
        logic               disc;
        logic               sv;
        logic [STW-1:0]     sw;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sv = cyc_end;
        if (cyc_end) st_d.sw = {dead_w, ov_w, pow_w};
        if (clear) begin
            st_d.fire = '0;
            st_d.disc = 1'b0;
        end else begin
            for (int i = 0; i < N_UNITS; i++) begin
                st_d.fire[i] = st_q.fire[i] | (|(ov_w & ~(N_UNITS'(1) << i)));
            end
            st_d.disc = st_q.disc | (|dead_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_cmd       = st_q.fire;
    assign disconnect_req = st_q.disc;
    assign status_valid   = st_q.sv;
    assign status_word    = st_q.sw;
    assign energised      = pow_w;
    assign ov_mark        = ov_w;
    assign dead_mark      = dead_w;

    // R5
    fire_follows_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ov_w) && !clear) |=> (fire_cmd != '0));

    // R7
    disc_follows_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dead_w) && !clear) |=> disconnect_req);

    // R9
    status_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> $past(cyc_end));

    // R8
    clear_drops_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fire_cmd == '0) && !disconnect_req);

endmodule

// File: tb/tcu_pulse_supervisor_bench.sv
module tcu_pulse_supervisor_bench;
    localparam int N  = 6;
    localparam int CT = 200;
    localparam int F  = 4;
    localparam int D  = 5;
    localparam int W  = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            clear;
    logic [N-1:0]    ind_n;
    logic [N-1:0]    fire_cmd, energised, ov_mark, dead_mark;
    logic            disconnect_req, status_valid;
    logic [3*N-1:0]  status_word;

    tcu_pulse_supervisor #(.N_UNITS(N), .CYCLE_TICKS(CT), .FILT_CLKS(F), .DEAD_CYCLES(D))
    u_tcu_pulse_supervisor (
        .clk(clk), .rst_n(rst_n), .clear(clear), .ind_n(ind_n),
        .fire_cmd(fire_cmd), .energised(energised), .ov_mark(ov_mark),
        .dead_mark(dead_mark), .disconnect_req(disconnect_req),
        .status_valid(status_valid), .status_word(status_word)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int edge_n = 0;
    int sv_seen = 0;

    // behavioural reference state
    logic [N-1:0]   m_s1, m_s2, m_filt, m_pulse, m_pow, m_ov, m_dead, m_fire;
    int             m_fc[N], m_cnt[N], m_sil[N];
    logic           m_disc, m_sv;
    logic [3*N-1:0] m_sw;

    // stimulus plan for one mains period
    int np[N], off1[N], off2[N];
    int clr_at, gl_unit, gl_at, mid_at;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s edge %0d: actual %h expected %h", tag, edge_n, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_filt = '0; m_pulse = '0;
        m_pow = '0; m_ov = '0; m_dead = '0; m_fire = '0;
        m_disc = 1'b0; m_sv = 1'b0; m_sw = '0;
        for (int i = 0; i < N; i++) begin m_fc[i] = 0; m_cnt[i] = 0; m_sil[i] = 0; end
    endtask

    task automatic model_edge(input logic [N-1:0] raw, input logic clr);
        bit ce;
        logic [N-1:0] nf;
        edge_n++;
        ce = ((edge_n % CT) == 0);
        for (int i = 0; i < N; i++)
            nf[i] = clr ? 1'b0 : (m_fire[i] | (|(m_ov & ~(6'b1 << i))));
        m_disc = clr ? 1'b0 : (m_disc | (|m_dead));
        m_sv = ce;
        if (ce) m_sw = {m_dead, m_ov, m_pow};
        m_fire = nf;
        for (int i = 0; i < N; i++) begin
            if (clr) begin
                m_pow[i] = 0; m_ov[i] = 0; m_dead[i] = 0; m_cnt[i] = 0; m_sil[i] = 0;
            end else begin
                if (ce) begin
                    if (m_cnt[i] == 0) begin
                        if (!m_dead[i]) begin
                            m_sil[i]++;
                            if (m_sil[i] == D) m_dead[i] = 1'b1;
                        end
                    end else m_sil[i] = 0;
                    m_cnt[i] = 0;
                end
                if (m_pulse[i]) begin
                    m_pow[i] = 1'b1;
                    m_sil[i] = 0;
                    if (m_cnt[i] > 0) begin m_ov[i] = 1'b1; m_cnt[i] = 2; end
                    else m_cnt[i] = 1;
                end
            end
            m_pulse[i] = 1'b0;
            if (m_s2[i] == m_filt[i]) m_fc[i] = 0;
            else if (m_fc[i] == F - 1) begin
                m_fc[i] = 0; m_filt[i] = m_s2[i]; m_pulse[i] = m_s2[i];
            end else m_fc[i]++;
        end
        m_s2 = m_s1;
        m_s1 = ~raw;
    endtask

    task automatic compare();
        chk("R5 fire_cmd", 32'(fire_cmd), 32'(m_fire));
        chk("R3 energised", 32'(energised), 32'(m_pow));
        chk("R4 ov_mark", 32'(ov_mark), 32'(m_ov));
        chk("R6 dead_mark", 32'(dead_mark), 32'(m_dead));
        chk("R7 disconnect_req", 32'(disconnect_req), 32'(m_disc));
        chk("R9 status_valid", 32'(status_valid), 32'(m_sv));
        chk("R9 status_word", 32'(status_word), 32'(m_sw));
    endtask

    task automatic step(input logic [N-1:0] nxt, input logic nclr);
        @(negedge clk);
        if (rst_n) model_edge(ind_n, clear);
        if (status_valid) sv_seen++;
        compare();
        ind_n = nxt;
        clear = nclr;
    endtask

    task automatic plan_default();
        for (int i = 0; i < N; i++) begin
            np[i] = 1; off1[i] = 20 + 10 * i; off2[i] = 120;
        end
        clr_at = -1; gl_unit = -1; gl_at = 0; mid_at = -1;
    endtask

    task automatic run_cycle();
        for (int t = 0; t < CT; t++) begin
            logic [N-1:0] v;
            v = '1;
            for (int i = 0; i < N; i++) begin
                if (np[i] >= 1 && t >= off1[i] && t < off1[i] + W) v[i] = 1'b0;
                if (np[i] >= 2 && t >= off2[i] && t < off2[i] + W) v[i] = 1'b0;
                if (gl_unit == i && t >= gl_at && t < gl_at + 2) v[i] = 1'b0;
            end
            step(v, (t == clr_at));
            // R2: a two-clock glitch must not energise the unit
            if (t == mid_at) chk("R2 glitch ignored", 32'(energised[5]), 32'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; clear = 1'b0; ind_n = '1;
        model_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1 reset fire_cmd", 32'(fire_cmd), 32'd0);
            chk("R1 reset marks", 32'({energised, ov_mark, dead_mark}), 32'd0);
            chk("R1 reset disconnect_req", 32'(disconnect_req), 32'd0);
            chk("R1 reset status", 32'({status_valid, status_word}), 32'd0);
        end
        rst_n = 1'b1;

        // period 0: glitch on unit 5, then every unit energises
        plan_default(); gl_unit = 5; gl_at = 5; mid_at = 60;
        run_cycle();
        chk("R3 all energised", 32'(energised), 32'h3f);

        // periods 1-2: steady single pulses
        plan_default(); run_cycle(); run_cycle();
        chk("R4 no ov on single pulses", 32'(ov_mark), 32'd0);

        // period 3: unit 2 double pulse
        plan_default(); np[2] = 2; run_cycle();
        chk("R4 ov on unit 2", 32'(ov_mark), 32'h04);
        chk("R5 fire on others", 32'(fire_cmd), 32'h3b);

        // period 4: manual clear, then pulses re-energise
        plan_default(); clr_at = 5; run_cycle();
        chk("R8 clear ov", 32'(ov_mark), 32'd0);
        chk("R8 clear fire", 32'(fire_cmd), 32'd0);

        // periods 5-6: unit 1 pulses late then early, straddling a boundary
        plan_default(); off1[1] = 190; run_cycle();
        plan_default(); off1[1] = 20; run_cycle();
        chk("R4 straddle not ov", 32'(ov_mark), 32'd0);

        // periods 7-12: unit 5 silent, unit 3 silent for D-1 periods
        for (int c = 7; c <= 12; c++) begin
            plan_default(); np[5] = 0;
            if (c <= 10) np[3] = 0;
            run_cycle();
        end
        chk("R6 unit 5 dead, unit 3 alive", 32'(dead_mark), 32'h20);
        chk("R7 disconnect raised", 32'(disconnect_req), 32'd1);

        // period 13: clear again
        plan_default(); clr_at = 5; run_cycle();
        chk("R8 clear dead", 32'(dead_mark), 32'd0);
        chk("R8 clear disconnect", 32'(disconnect_req), 32'd0);

        // period 14: two units overvoltage at once
        plan_default(); np[0] = 2; np[1] = 2; run_cycle();
        chk("R4 ov on units 0,1", 32'(ov_mark), 32'h03);
        chk("R5 all fire", 32'(fire_cmd), 32'h3f);

        for (int k = 0; k < 4; k++) step('1, 1'b0);
        chk("R9 one strobe per period", 32'(sv_seen), 32'(edge_n / CT));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule